// File: doc/BRIEF.md
# Receive frame status and error summary

This block sits beside a serial receiver. While a frame arrives it counts the delivered bits, one per cycle in which `bit_vld` is high. It also remembers any abort, CRC-failure or FIFO-overrun indication raised during the frame. When `frame_end` is strobed it judges the frame. The length is compared against a configurable minimum and maximum, and a length that is not a whole number of octets is flagged on its own. The verdict is packed into a 64-bit status word destined for the first descriptor of the frame. All flags sit in the top byte, and a start-of-packet bit at the very top marks the word as complete.

Every judged frame also feeds a sticky six-bit error summary. That summary is masked bit by bit to form an interrupt request. Reading the summary clears it, but an error that lands in the same cycle as the read is retained. The length counter saturates, so an oversized frame can never wrap round and pass as a short one.

Top module: `rx_frame_status`

## Requirements
- R1: One clock after a cycle with `frame_end` high, `stat_vld` is high for exactly one cycle. In that cycle `stat_word[63]` (start of packet) is 1 and `stat_word[55:0]` is zero. `stat_vld` is low in every other cycle.
- R2: The frame length is the number of cycles with `bit_vld` high since the previous `frame_end`, including a bit that coincides with `frame_end`. `stat_word[60]` (short) is set when length < `min_bits`, and `stat_word[59]` (long) is set when length > `max_bits`.
- R3: `stat_word[58]` (octet) is set exactly when the length modulo 8 is nonzero. This holds for lengths beyond the counter range as well.
- R4: `stat_word[57]` (abort), `stat_word[56]` (CRC) and `stat_word[61]` (overrun) are each set when `abort_in`, `crc_bad_in` or `overrun_in` respectively was high in any cycle after the previous `frame_end`, up to and including the cycle of this `frame_end`.
- R5: `stat_word[62]` (good) is 1 exactly when bits 61:56 of the same word are all zero.
- R6: The bit counter saturates at 2^CNT_W-1. A frame with more bits than that is always reported long and never short.
- R7: `sum_rdata` holds six sticky bits: bit0 CRC, bit1 abort, bit2 octet, bit3 long, bit4 short, bit5 overrun. Each equals `stat_word` bit 56+i. A frame's errors are ORed in at the same edge that raises `stat_vld`.
- R8: `irq` is high exactly when some bit is set in both `sum_rdata` and `err_mask`.
- R9: A cycle with `sum_rd` high clears every summary bit at the next edge, which drops `irq`.
- R10: Errors of a frame whose `frame_end` coincides with `sum_rd` are kept in the summary after the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | One received bit delivered this cycle |
| frame_end | input | 1 | Current frame ends this cycle |
| abort_in | input | 1 | Abort seen on the line |
| crc_bad_in | input | 1 | CRC check failed |
| overrun_in | input | 1 | Receive FIFO overran |
| min_bits | input | CNT_W | Minimum legal frame length in bits |
| max_bits | input | CNT_W | Maximum legal frame length in bits |
| err_mask | input | 6 | Interrupt enable per summary bit |
| sum_rd | input | 1 | Read strobe of the error summary |
| sum_rdata | output | 6 | Error summary contents |
| irq | output | 1 | Interrupt request |
| stat_word | output | 64 | Status word for the frame's first descriptor |
| stat_vld | output | 1 | Status word valid pulse |

## Verification
Two functions can coincide here. One is the summary clear triggered by `sum_rd`. The other is the summary update from a frame whose `frame_end` lands in the same cycle. The bench provokes this on purpose by ending an erroneous frame with the read strobe high, and it also lets random reads fall on random frame ends. A behavioural model applies "clear, then OR in the new errors" and is compared with `sum_rdata` and `irq` every cycle, so losing the colliding error, or failing to clear the old bits, shows as a mismatch on the following cycle.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   localparam int NUM_ERR  = 6;
   localparam int WORD_W   = 64;
   localparam int FLAG_LSB = 56;
   localparam int GOOD_BIT = 62;
   localparam int SOP_BIT  = 63;

   // index of each error in the summary; status bit is FLAG_LSB + index
   typedef enum int unsigned {
      E_CRC   = 0,
      E_ABORT = 1,
      E_OCTET = 2,
      E_LONG  = 3,
      E_SHORT = 4,
      E_OVR   = 5
   } err_idx_e;

   typedef logic [NUM_ERR-1:0] err_vec_t;

   function automatic logic [WORD_W-1:0] pack_status(input err_vec_t e);
      logic [WORD_W-1:0] w;
      w = '0;
      w[FLAG_LSB +: NUM_ERR] = e;
      w[GOOD_BIT]            = ~(|e);
      w[SOP_BIT]             = 1'b1;
      return w;
   endfunction

endpackage

// File: rtl/rxs_len_count.sv
module rxs_len_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             frame_end,
   output logic [CNT_W-1:0] len,
   output logic             over,
   output logic [2:0]       oct_rem
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic [2:0]       m8_q;

   // length including the bit of this cycle, held at CMAX once full
   always_comb begin
      if (bit_vld && cnt_q != CMAX) len = cnt_q + 1'b1;
      else                          len = cnt_q;
      over    = ovf_q | (bit_vld & (cnt_q == CMAX));
      oct_rem = m8_q + {2'b00, bit_vld};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         m8_q  <= '0;
      end else if (frame_end) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         m8_q  <= '0;
      end else begin
         cnt_q <= len;
         ovf_q <= over;
         m8_q  <= oct_rem;
      end
   end

   // R6: a full counter never wraps inside a frame
   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && cnt_q == CMAX) |=> (cnt_q == CMAX));

   // R6: once beyond range the frame stays marked over-length
   assert_over_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && over) |=> over);

endmodule

// File: rtl/rxs_classify.sv
module rxs_classify
   import rxs_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_end,
   input  logic              abort_in,
   input  logic              crc_bad_in,
   input  logic              overrun_in,
   input  logic [CNT_W-1:0]  len,
   input  logic              over,
   input  logic [2:0]        oct_rem,
   input  logic [CNT_W-1:0]  min_bits,
   input  logic [CNT_W-1:0]  max_bits,
   output err_vec_t          err_now,
   output logic [WORD_W-1:0] stat_word,
   output logic              stat_vld
);

   logic abort_q, crc_q, ovr_q;

   always_comb begin
      err_now          = '0;
      err_now[E_CRC]   = crc_q   | crc_bad_in;
      err_now[E_ABORT] = abort_q | abort_in;
      err_now[E_OVR]   = ovr_q   | overrun_in;
      err_now[E_OCTET] = (oct_rem != 3'd0);
      err_now[E_LONG]  = over | (len > max_bits);
      err_now[E_SHORT] = ~over & (len < min_bits);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_q <= 1'b0;
         crc_q   <= 1'b0;
         ovr_q   <= 1'b0;
      end else if (frame_end) begin
         abort_q <= 1'b0;
         crc_q   <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         abort_q <= abort_q | abort_in;
         crc_q   <= crc_q   | crc_bad_in;
         ovr_q   <= ovr_q   | overrun_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_vld  <= 1'b0;
         stat_word <= '0;
      end else begin
         stat_vld <= frame_end;
         if (frame_end) stat_word <= pack_status(err_now);
      end
   end

   // R1: valid pulse follows the end strobe by one clock
   assert_vld_after_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> stat_vld);
   assert_vld_only_after_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> !stat_vld);
   // R1: a presented word carries start-of-packet and clean low bits
   assert_word_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> (stat_word[SOP_BIT] && stat_word[FLAG_LSB-1:0] == '0));
   // R5: good never appears together with an error flag
   assert_good_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> !(stat_word[GOOD_BIT] && (|stat_word[FLAG_LSB +: NUM_ERR])));
   // R6: an over-range frame is never called short
   assert_over_not_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && over) |=> (stat_word[FLAG_LSB + E_LONG] && !stat_word[FLAG_LSB + E_SHORT]));

endmodule

// File: rtl/rxs_err_summary.sv
module rxs_err_summary #(
   parameter int NUM     = 6,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set_vec,
   input  logic           set_en,
   input  logic           rd,
   input  logic [NUM-1:0] mask,
   output logic [NUM-1:0] sum,
   output logic           irq
);

   for (genvar i = 0; i < NUM; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum[i] <= 1'b0;
         else        sum[i] <= (sum[i] & ~rd) | (set_en & set_vec[i]);
      end
   end

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(sum & mask);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(sum & mask);
      // R9: a read with nothing new leaves the request low
      assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (rd && !set_en) |=> !irq);
   end

   // R7: bits stay set until read
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> ((sum & $past(sum)) == $past(sum)));
   // R9: a read with no new event empties the summary
   assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !set_en) |=> (sum == '0));
   // R10: an event colliding with a read survives
   assert_keep_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && set_en) |=> ((sum & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
   import rxs_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              frame_end,
   input  logic              abort_in,
   input  logic              crc_bad_in,
   input  logic              overrun_in,
   input  logic [CNT_W-1:0]  min_bits,
   input  logic [CNT_W-1:0]  max_bits,
   input  logic [5:0]        err_mask,
   input  logic              sum_rd,
   output logic [5:0]        sum_rdata,
   output logic              irq,
   output logic [63:0]       stat_word,
   output logic              stat_vld
);

   if (CNT_W < 4 || CNT_W > 32) begin : g_bad_cnt_w
      $error("rx_frame_status: CNT_W must lie in 4..32");
   end
   if (NUM_ERR != 6 || WORD_W != 64) begin : g_bad_pkg
      $error("rx_frame_status: package layout does not match ports");
   end

   logic [CNT_W-1:0] len;
   logic             over;
   logic [2:0]       oct_rem;
   err_vec_t         err_now;

   rxs_len_count #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld   (bit_vld),
      .frame_end (frame_end),
      .len       (len),
      .over      (over),
      .oct_rem   (oct_rem)
   );

   rxs_classify #(.CNT_W(CNT_W)) u_cls (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_end  (frame_end),
      .abort_in   (abort_in),
      .crc_bad_in (crc_bad_in),
      .overrun_in (overrun_in),
      .len        (len),
      .over       (over),
      .oct_rem    (oct_rem),
      .min_bits   (min_bits),
      .max_bits   (max_bits),
      .err_now    (err_now),
      .stat_word  (stat_word),
      .stat_vld   (stat_vld)
   );

   rxs_err_summary #(.NUM(NUM_ERR), .REG_IRQ(REG_IRQ)) u_sum (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (err_now),
      .set_en  (frame_end),
      .rd      (sum_rd),
      .mask    (err_mask),
      .sum     (sum_rdata),
      .irq     (irq)
   );

   // R7: summary picks up exactly the flags of the word just presented
   assert_sum_has_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> ((sum_rdata & stat_word[FLAG_LSB +: NUM_ERR]) == stat_word[FLAG_LSB +: NUM_ERR]));

endmodule

// File: tb/sim_rx_frame_status.sv
module sim_rx_frame_status;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bit_vld = 0, frame_end = 0, abort_in = 0, crc_bad_in = 0, overrun_in = 0;
   logic [W-1:0] min_bits = 0, max_bits = 0;
   logic [5:0]   err_mask = 0;
   logic         sum_rd = 0;
   logic [5:0]   sum_rdata;
   logic         irq;
   logic [63:0]  stat_word;
   logic         stat_vld;

   int total = 0, bad = 0;
   bit started = 0, done = 0;

   always #2 clk = ~clk;

   rx_frame_status #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .frame_end(frame_end),
      .abort_in(abort_in), .crc_bad_in(crc_bad_in), .overrun_in(overrun_in),
      .min_bits(min_bits), .max_bits(max_bits), .err_mask(err_mask),
      .sum_rd(sum_rd), .sum_rdata(sum_rdata), .irq(irq),
      .stat_word(stat_word), .stat_vld(stat_vld));

   // behavioural reference
   int        m_len = 0;
   bit        m_ab = 0, m_crc = 0, m_ov = 0;
   bit        e_vld = 0;
   bit [63:0] e_word = 0;
   bit [5:0]  e_sum = 0;

   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) begin
         m_len <= 0; m_ab <= 0; m_crc <= 0; m_ov <= 0;
         e_vld <= 0; e_word <= 0; e_sum <= 0;
      end else begin
         int L;
         bit [5:0] f;
         L = m_len + (bit_vld ? 1 : 0);
         f[0] = m_crc | crc_bad_in;
         f[1] = m_ab | abort_in;
         f[2] = (L % 8) != 0;
         f[3] = L > int'(max_bits);
         f[4] = L < int'(min_bits);
         f[5] = m_ov | overrun_in;
         e_vld <= frame_end;
         if (frame_end) begin
            e_word <= {1'b1, (f == 6'd0), f, 56'd0};
            m_len <= 0; m_ab <= 0; m_crc <= 0; m_ov <= 0;
         end else begin
            m_len <= L;
            m_ab  <= m_ab | abort_in;
            m_crc <= m_crc | crc_bad_in;
            m_ov  <= m_ov | overrun_in;
         end
         e_sum <= (sum_rd ? 6'd0 : e_sum) | (frame_end ? f : 6'd0);
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (started && !done) begin
      chk("R1 stat_vld", {63'd0, stat_vld}, {63'd0, e_vld});
      chk("R8 irq", {63'd0, irq}, {63'd0, |(e_sum & err_mask)});
      chk("R7 R9 R10 summary", {58'd0, sum_rdata}, {58'd0, e_sum});
      if (e_vld) begin
         chk("R1 sop/low bits", {stat_word[63], stat_word[55:0]}, {e_word[63], e_word[55:0]});
         chk("R2 R6 long/short", {62'd0, stat_word[60:59]}, {62'd0, e_word[60:59]});
         chk("R3 octet", {63'd0, stat_word[58]}, {63'd0, e_word[58]});
         chk("R4 abort/crc/overrun", {61'd0, stat_word[61], stat_word[57:56]},
             {61'd0, e_word[61], e_word[57:56]});
         chk("R5 good", {63'd0, stat_word[62]}, {63'd0, e_word[62]});
      end
   end

   task automatic drv(input bit b, input bit e, input bit a, input bit c, input bit o, input bit r);
      @(negedge clk); #1;
      bit_vld = b; frame_end = e; abort_in = a; crc_bad_in = c; overrun_in = o; sum_rd = r;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0);
   endtask

   task automatic frame(input int n, input int ab_at, input bit crc, input bit ov, input bit rd_end);
      if (n == 0) drv(0, 1, 0, crc, ov, rd_end);
      for (int i = 0; i < n; i++)
         drv(1, i == n-1, i == ab_at, crc && i == n-1, ov && i == n/2, rd_end && i == n-1);
      idle(2);
   endtask

   task automatic rd_sum();
      drv(0, 0, 0, 0, 0, 1);
      idle(2);
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      finish_run();
   end

   initial begin
      min_bits = 8'd16; max_bits = 8'd64; err_mask = 6'h3F;
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      idle(2);
      frame(16, -1, 0, 0, 0);   // R5 good frame
      frame(24, -1, 0, 0, 0);
      frame(13, -1, 0, 0, 0);   // R2 short, R3 octet
      rd_sum();                 // R9
      frame(72, -1, 0, 0, 0);   // R2 long
      frame(0, -1, 0, 0, 0);    // R2 zero length short
      rd_sum();
      frame(20, 5, 0, 0, 0);    // R4 abort mid frame
      frame(32, -1, 1, 0, 0);   // R4 crc at end
      frame(40, -1, 0, 1, 0);   // R4 overrun mid frame
      rd_sum();
      frame(17, 3, 0, 0, 1);    // R10 read collides with end
      idle(2);
      rd_sum();
      err_mask = 6'b000100;     // R8 octet only enabled
      frame(24, 2, 0, 0, 0);    // abort only: no irq
      frame(19, -1, 0, 0, 0);   // octet: irq
      rd_sum();
      err_mask = 6'h3F;
      max_bits = 8'd200; min_bits = 8'd0;
      frame(300, -1, 0, 0, 0);  // R6 saturation, long, octet
      max_bits = 8'd255;
      frame(256, -1, 0, 0, 0);  // R6 just past range
      min_bits = 8'd255;
      frame(255, -1, 0, 0, 0);  // counter full, neither long nor short
      frame(520, -1, 0, 0, 0);  // R6 far past range, never short
      rd_sum();
      min_bits = 8'd16; max_bits = 8'd64;
      for (int k = 0; k < 40; k++) begin
         int n;
         n = $urandom_range(0, 90);
         for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 3) == 0) drv(0, 0, 0, 0, 0, $urandom_range(0, 7) == 0);
            drv(1, i == n-1, $urandom_range(0, 60) == 0, $urandom_range(0, 60) == 0,
                $urandom_range(0, 60) == 0, $urandom_range(0, 5) == 0);
         end
         if (n == 0) drv(0, 1, 0, 0, 0, $urandom_range(0, 1) == 1);
         idle($urandom_range(0, 2));
      end
      idle(3);
      finish_run();
   end

endmodule